// File: doc/BRIEF.md
# Byte-wide host bus master

This block is a bus master for a narrow parallel host bus. It takes one 32-bit request at a time on a local valid/ready interface and carries it out as a series of single-byte bus cycles. The request can target a register (16-bit address) or memory (22-bit address), and it can be a read or a write. The bus has four active-low control lines: write strobe, read strobe, chip select and ready. It also has a 4-bit sub-address and an 8-bit data path, with the output and input halves kept separate and an output enable between them. Every byte travels to or from a sub-address, and each sub-address names one byte lane of a data word or of an address.

A write byte takes two phases. The first is a setup phase with the strobes high. The second is a strobe phase, in which write strobe and chip select are low and the sub-address and data stay unchanged. A read byte also drives its sub-address first. It then pulls read strobe and chip select low and samples the data. Last comes a recovery phase in which every strobe is high and the data path is released.

Register and memory requests differ in which byte starts the slave's work. Writing the register mode sub-address starts a register access. Writing memory address byte 0 starts a memory access. After the starting byte the master polls ready at a fixed interval, and it gives up with an error after a fixed number of polls. A streaming option lets memory writes skip the ready wait. Instead the master sends a fixed number of idle words, with every line high and the data path driven to all ones.

Top module: `hbus_master`

## Requirements
- R1: After reset, write strobe, read strobe and chip select are high, the output enable is low, `req_ready` is high, and `done`, `err` and `rd_data` are zero.
- R2: A byte write first drives its sub-address and data with the output enable high and write strobe and chip select high, for PHASE_CYC cycles. It then pulls write strobe and chip select low for PHASE_CYC cycles, with the sub-address and data unchanged. Read strobe stays high throughout.
- R3: A register write sends these bytes in order: data lanes 0, 1, 2, 3 to sub-addresses 0x0 to 0x3, then address bits 7:0 to 0x4, then address bits 15:8 to 0x5, then the value 0x01 to the mode sub-address 0x7. Writing the mode sub-address starts the ready wait.
- R4: A register read sends address bits 7:0 to 0x4, address bits 15:8 to 0x5, then 0x00 to 0x7. After ready it reads sub-addresses 0x0, 0x1, 0x2, 0x3 in that order. The byte read from sub-address 0x0+k lands in `rd_data[8k+7:8k]`.
- R5: A memory write sends data lanes 0 to 3 to sub-addresses 0x8 to 0xB. It then sends address byte 2 to 0xE, address bits 15:8 to 0xD, and address bits 7:0 to 0xC. Address byte 2 is {1 (write), 0, address bits 21:16}. The byte to 0xC starts the ready wait.
- R6: A memory read sends {0 (read), 0, address bits 21:16} to 0xE, then the bytes to 0xD and 0xC. After ready it reads sub-addresses 0xB, 0xA, 0x9, 0x8 in that order, and sub-address 0x8+k fills lane k of `rd_data`.
- R7: A byte read drives its sub-address with all strobes high and the output enable low. It then pulls read strobe and chip select low. After read strobe rises, there is a cycle with write strobe, read strobe and chip select all high and the output enable low.
- R8: Ready (active low) is sampled once every POLL_CYC cycles. If POLL_MAX samples in a row find it high, the request ends with `err`=1 and `rd_data`=0, and no byte reads are made.
- R9: When `stream_en` is set on a memory write, the master does not wait for ready. After the last address byte it drives exactly IDLE_WORDS idle words: strobes high, sub-address 0xF, data 0xFF, output enable high. The request then ends with `err`=0. `stream_en` has no effect on the other three request types.
- R10: `req_ready` is high only while idle. `done` is a one-cycle pulse. A successful request reports `err`=0, and a write reports `rd_data`=0.
- R11: The output enable is never high while read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, request accepted when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = register space |
| stream_en | input | 1 | Streamed memory write: idle words instead of ready wait |
| req_addr | input | 22 | Address (register uses bits 15:0) |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read result, valid with done |
| err | output | 1 | Ready timeout, valid with done |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rdy_n | input | 1 | Slave ready, active low |
| bus_sub | output | 4 | Sub-address |
| bus_dout | output | 8 | Data driven to the bus |
| bus_doe | output | 1 | Data output enable |
| bus_din | input | 8 | Data read from the bus |

## Verification
The bench builds the master with PHASE_CYC=2, POLL_CYC=3, POLL_MAX=8 and IDLE_WORDS=6. The timeout window is therefore only 24 cycles, so a slave that never answers reaches the error path quickly. A slave delay of 20 cycles is answered only on one of the last polls, just inside that window. The two-cycle phases make the setup/strobe hold and the read recovery phase visible as separate cycles. A streamed write against a silent slave shows that the ready wait really is skipped.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

  typedef enum logic [1:0] {
    OP_REG_WR = 2'd0,
    OP_REG_RD = 2'd1,
    OP_MEM_WR = 2'd2,
    OP_MEM_RD = 2'd3
  } hop_e;

  localparam int ADDR_W = 22;
  localparam int WORD_W = 32;

  localparam logic [3:0] SA_RDAT0 = 4'h0;
  localparam logic [3:0] SA_RADR0 = 4'h4;
  localparam logic [3:0] SA_RADR1 = 4'h5;
  localparam logic [3:0] SA_RMODE = 4'h7;
  localparam logic [3:0] SA_MDAT0 = 4'h8;
  localparam logic [3:0] SA_MADR0 = 4'hC;
  localparam logic [3:0] SA_MADR1 = 4'hD;
  localparam logic [3:0] SA_MADR2 = 4'hE;
  localparam logic [3:0] SA_IDLE  = 4'hF;

  localparam logic [7:0] RMODE_WR = 8'h01;
  localparam logic [7:0] RMODE_RD = 8'h00;

  typedef struct packed {
    logic [3:0] sub;
    logic [7:0] dat;
  } step_t;

  function automatic logic [7:0] lane_of(input logic [WORD_W-1:0] w, input logic [1:0] k);
    case (k)
      2'd0:    return w[7:0];
      2'd1:    return w[15:8];
      2'd2:    return w[23:16];
      default: return w[31:24];
    endcase
  endfunction

  function automatic logic is_read_op(input hop_e op);
    return op[0];
  endfunction

  // number of byte writes issued before the ready wait
  function automatic logic [2:0] wr_count(input hop_e op);
    return is_read_op(op) ? 3'd3 : 3'd7;
  endfunction

  // sub-address and data of write step i
  function automatic step_t wr_step(input hop_e op, input logic [2:0] i,
                                    input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] w);
    step_t s;
    s.sub = SA_IDLE;
    s.dat = 8'hFF;
    case (op)
      OP_REG_WR: begin
        if (i < 3'd4) begin
          s.sub = SA_RDAT0 + {2'b00, i[1:0]};
          s.dat = lane_of(w, i[1:0]);
        end else if (i == 3'd4) begin
          s.sub = SA_RADR0; s.dat = a[7:0];
        end else if (i == 3'd5) begin
          s.sub = SA_RADR1; s.dat = a[15:8];
        end else begin
          s.sub = SA_RMODE; s.dat = RMODE_WR;
        end
      end
      OP_REG_RD: begin
        if (i == 3'd0) begin
          s.sub = SA_RADR0; s.dat = a[7:0];
        end else if (i == 3'd1) begin
          s.sub = SA_RADR1; s.dat = a[15:8];
        end else begin
          s.sub = SA_RMODE; s.dat = RMODE_RD;
        end
      end
      OP_MEM_WR: begin
        if (i < 3'd4) begin
          s.sub = SA_MDAT0 + {2'b00, i[1:0]};
          s.dat = lane_of(w, i[1:0]);
        end else if (i == 3'd4) begin
          s.sub = SA_MADR2; s.dat = {1'b1, 1'b0, a[21:16]};
        end else if (i == 3'd5) begin
          s.sub = SA_MADR1; s.dat = a[15:8];
        end else begin
          s.sub = SA_MADR0; s.dat = a[7:0];
        end
      end
      default: begin
        if (i == 3'd0) begin
          s.sub = SA_MADR2; s.dat = {1'b0, 1'b0, a[21:16]};
        end else if (i == 3'd1) begin
          s.sub = SA_MADR1; s.dat = a[15:8];
        end else begin
          s.sub = SA_MADR0; s.dat = a[7:0];
        end
      end
    endcase
    return s;
  endfunction

  // result lane filled by read step k
  function automatic logic [1:0] rd_lane(input hop_e op, input logic [1:0] k);
    return (op == OP_MEM_RD) ? (2'd3 - k) : k;
  endfunction

  // sub-address of read step k
  function automatic logic [3:0] rd_sub(input hop_e op, input logic [1:0] k);
    return ((op == OP_MEM_RD) ? SA_MDAT0 : SA_RDAT0) + {2'b00, rd_lane(op, k)};
  endfunction

endpackage

// File: rtl/hbus_byte_phy.sv
module hbus_byte_phy
  import hbus_pkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rd_i,
  input  logic [3:0] sub_i,
  input  logic [7:0] dat_i,
  input  logic [7:0] din,
  output logic       wr_n,
  output logic       rd_n,
  output logic       cs_n,
  output logic       doe,
  output logic [3:0] sub_o,
  output logic [7:0] dout,
  output logic [7:0] rbyte,
  output logic       byte_done
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CLAST = CW'(PHASE_CYC - 1);

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_STROBE, P_RECOV} phase_e;

  phase_e        ph;
  logic [CW-1:0] cnt;
  logic          rd_q;
  logic [3:0]    sub_q;
  logic [7:0]    dat_q;
  logic          phase_end;
  logic          drive;
  logic          wr_phase;

  assign phase_end = (cnt == CLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= P_IDLE;
      cnt   <= '0;
      rd_q  <= 1'b0;
      sub_q <= SA_IDLE;
      dat_q <= 8'hFF;
      rbyte <= 8'h00;
    end else begin
      case (ph)
        P_IDLE: begin
          if (start) begin
            ph    <= P_SETUP;
            cnt   <= '0;
            rd_q  <= rd_i;
            sub_q <= sub_i;
            dat_q <= dat_i;
          end
        end
        P_SETUP: begin
          if (phase_end) begin
            ph  <= P_STROBE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        P_STROBE: begin
          if (phase_end) begin
            cnt <= '0;
            if (rd_q) begin
              rbyte <= din;
              ph    <= P_RECOV;
            end else begin
              ph <= P_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (phase_end) begin
            ph  <= P_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    drive     = (ph == P_SETUP) || (ph == P_STROBE);
    wr_phase  = drive && !rd_q;
    sub_o     = drive ? sub_q : SA_IDLE;
    dout      = wr_phase ? dat_q : 8'hFF;
    doe       = wr_phase;
    wr_n      = !((ph == P_STROBE) && !rd_q);
    rd_n      = !((ph == P_STROBE) && rd_q);
    cs_n      = (ph != P_STROBE);
    byte_done = phase_end && (((ph == P_STROBE) && !rd_q) || (ph == P_RECOV));
  end

endmodule

// File: rtl/hbus_ready_poll.sv
module hbus_ready_poll #(
  parameter int POLL_CYC = 16,
  parameter int POLL_MAX = 101
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rdy_n,
  output logic active,
  output logic hit,
  output logic expire
);
  localparam int TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
  localparam logic [TW-1:0] TLAST = TW'(POLL_CYC - 1);
  localparam logic [PW-1:0] PLAST = PW'(POLL_MAX - 1);

  logic [TW-1:0] tick;
  logic [PW-1:0] polls;
  logic          tick_end;

  assign tick_end = active && (tick == TLAST);
  assign hit      = tick_end && !rdy_n;
  assign expire   = tick_end && rdy_n && (polls == PLAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
      polls  <= '0;
    end else if (start) begin
      active <= 1'b1;
      tick   <= '0;
      polls  <= '0;
    end else if (active) begin
      if (tick_end) begin
        tick <= '0;
        if (hit || expire) active <= 1'b0;
        else               polls  <= polls + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hbus_master.sv
module hbus_master
  import hbus_pkg::*;
#(
  parameter int PHASE_CYC  = 2,
  parameter int POLL_CYC   = 16,
  parameter int POLL_MAX   = 101,
  parameter int IDLE_WORDS = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_mem,
  input  logic        stream_en,
  input  logic [21:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic [31:0] rd_data,
  output logic        err,
  output logic        bus_wr_n,
  output logic        bus_rd_n,
  output logic        bus_cs_n,
  input  logic        bus_rdy_n,
  output logic [3:0]  bus_sub,
  output logic [7:0]  bus_dout,
  output logic        bus_doe,
  input  logic [7:0]  bus_din
);
  localparam int GW = (IDLE_WORDS > 1) ? $clog2(IDLE_WORDS) : 1;
  localparam logic [GW-1:0] GLAST = GW'(IDLE_WORDS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_BUSY, S_WAIT, S_GAP} state_e;

  state_e          state;
  hop_e            op_q;
  logic            strm_q;
  logic [21:0]     addr_q;
  logic [31:0]     wdat_q;
  logic [3:0]      idx_q;
  logic [31:0]     rbuf;
  logic [31:0]     rbuf_nx;
  logic [GW-1:0]   gap_cnt;
  logic            done_q;
  logic            err_q;
  logic [31:0]     rd_q;

  // named internal events
  logic            accept;
  logic [3:0]      n_wr;
  logic            rd_phase;
  logic [1:0]      cur_k;
  logic [1:0]      cur_lane;
  step_t           cur_step;
  logic [3:0]      phy_sub_in;
  logic            last_wr;
  logic            last_rd;
  logic            stream_gap;
  logic            phy_start;
  logic            poll_start;
  logic            poll_active;
  logic            poll_hit;
  logic            poll_expire;
  logic            gap_active;
  logic            byte_done;
  logic [7:0]      phy_rbyte;
  logic            phy_doe;

  assign req_ready  = (state == S_IDLE);
  assign accept     = req_valid && req_ready;
  assign n_wr       = {1'b0, wr_count(op_q)};
  assign rd_phase   = (idx_q >= n_wr);
  assign cur_k      = 2'(idx_q - n_wr);
  assign cur_lane   = rd_lane(op_q, cur_k);
  assign cur_step   = wr_step(op_q, idx_q[2:0], addr_q, wdat_q);
  assign phy_sub_in = rd_phase ? rd_sub(op_q, cur_k) : cur_step.sub;
  assign last_wr    = !rd_phase && (idx_q == n_wr - 4'd1);
  assign last_rd    = rd_phase && (cur_k == 2'd3);
  assign stream_gap = strm_q && (op_q == OP_MEM_WR);
  assign phy_start  = (state == S_ISSUE);
  assign poll_start = (state == S_BUSY) && byte_done && last_wr && !stream_gap;
  assign gap_active = (state == S_GAP);

  always_comb begin
    rbuf_nx = rbuf;
    rbuf_nx[{cur_lane, 3'b000} +: 8] = phy_rbyte;
  end

  hbus_byte_phy #(.PHASE_CYC(PHASE_CYC)) u_phy (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (phy_start),
    .rd_i      (rd_phase),
    .sub_i     (phy_sub_in),
    .dat_i     (cur_step.dat),
    .din       (bus_din),
    .wr_n      (bus_wr_n),
    .rd_n      (bus_rd_n),
    .cs_n      (bus_cs_n),
    .doe       (phy_doe),
    .sub_o     (bus_sub),
    .dout      (bus_dout),
    .rbyte     (phy_rbyte),
    .byte_done (byte_done)
  );

  hbus_ready_poll #(.POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u_poll (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (poll_start),
    .rdy_n  (bus_rdy_n),
    .active (poll_active),
    .hit    (poll_hit),
    .expire (poll_expire)
  );

  // idle words reuse the phy's all-ones idle drive, with the data path enabled
  assign bus_doe = phy_doe || gap_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= OP_REG_WR;
      strm_q  <= 1'b0;
      addr_q  <= '0;
      wdat_q  <= '0;
      idx_q   <= '0;
      rbuf    <= '0;
      gap_cnt <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q   <= hop_e'({req_mem, ~req_write});
            strm_q <= stream_en;
            addr_q <= req_addr;
            wdat_q <= req_wdata;
            idx_q  <= '0;
            rbuf   <= '0;
            state  <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_BUSY;
        S_BUSY: begin
          if (byte_done) begin
            if (rd_phase) rbuf <= rbuf_nx;
            if (last_wr) begin
              gap_cnt <= '0;
              state   <= stream_gap ? S_GAP : S_WAIT;
            end else if (last_rd) begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
              rd_q   <= rbuf_nx;
              state  <= S_IDLE;
            end else begin
              idx_q <= idx_q + 4'd1;
              state <= S_ISSUE;
            end
          end
        end
        S_WAIT: begin
          if (poll_hit) begin
            if (is_read_op(op_q)) begin
              idx_q <= idx_q + 4'd1;
              state <= S_ISSUE;
            end else begin
              done_q <= 1'b1;
              err_q  <= 1'b0;
              rd_q   <= '0;
              state  <= S_IDLE;
            end
          end else if (poll_expire) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            rd_q   <= '0;
            state  <= S_IDLE;
          end
        end
        S_GAP: begin
          if (gap_cnt == GLAST) begin
            done_q <= 1'b1;
            err_q  <= 1'b0;
            rd_q   <= '0;
            state  <= S_IDLE;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done    = done_q;
  assign err     = err_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/hbus_master_chk.sv
module hbus_master_chk #(
  parameter int POLL_CYC = 16,
  parameter int POLL_MAX = 101
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       bus_wr_n,
  input logic       bus_rd_n,
  input logic       bus_cs_n,
  input logic       bus_doe,
  input logic [3:0] bus_sub,
  input logic [7:0] bus_dout,
  input logic       poll_active,
  input logic       gap_active
);
  localparam int LIMIT = POLL_CYC * POLL_MAX;
  localparam int LW    = $clog2(LIMIT + 2);

  logic [LW-1:0] wait_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wait_len <= '0;
    else if (poll_active) wait_len <= wait_len + 1'b1;
    else                  wait_len <= '0;
  end

  a_r11_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_doe && !bus_rd_n));

  a_r2_write_selects: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> (!bus_cs_n && bus_rd_n && bus_doe));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> ($stable(bus_sub) && $stable(bus_dout)));

  a_r7_read_selects: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> (!bus_cs_n && bus_wr_n));

  a_r7_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> (bus_cs_n && bus_wr_n && !bus_doe));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r1_idle_pins: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_wr_n && bus_rd_n && bus_cs_n && !bus_doe));

  a_r8_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> (wait_len < LW'(LIMIT)));

  a_r9_no_poll_in_gap: assert property (@(posedge clk) disable iff (!rst_n)
    gap_active |-> !poll_active);

endmodule

bind hbus_master hbus_master_chk #(.POLL_CYC(POLL_CYC), .POLL_MAX(POLL_MAX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .done        (done),
  .bus_wr_n    (bus_wr_n),
  .bus_rd_n    (bus_rd_n),
  .bus_cs_n    (bus_cs_n),
  .bus_doe     (bus_doe),
  .bus_sub     (bus_sub),
  .bus_dout    (bus_dout),
  .poll_active (poll_active),
  .gap_active  (gap_active)
);

// File: tb/tb_hbus_master.sv
module tb_hbus_master;
  localparam int PHASE_CYC  = 2;
  localparam int POLL_CYC   = 3;
  localparam int POLL_MAX   = 8;
  localparam int IDLE_WORDS = 6;

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic        strm;
    logic [21:0] addr;
    logic [31:0] wdata;
    logic [31:0] sword;
    logic [7:0]  dly;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 1'b0, 22'h001234, 32'hDEADBEEF, 32'h00000000, 8'd2},
    '{1'b0, 1'b0, 1'b0, 22'h00ABCD, 32'h00000000, 32'h01234567, 8'd5},
    '{1'b1, 1'b1, 1'b0, 22'h3FA55A, 32'hCAFEF00D, 32'h00000000, 8'd0},
    '{1'b0, 1'b1, 1'b0, 22'h2B0F1E, 32'h00000000, 32'h89ABCDEF, 8'd7},
    '{1'b1, 1'b1, 1'b1, 22'h012345, 32'h11223344, 32'h00000000, 8'd255},
    '{1'b1, 1'b0, 1'b1, 22'h00BEEF, 32'h55667788, 32'h00000000, 8'd255},
    '{1'b0, 1'b1, 1'b0, 22'h100000, 32'h00000000, 32'hFFFFFFFF, 8'd255},
    '{1'b0, 1'b0, 1'b0, 22'h00FF00, 32'h00000000, 32'hA5C3E781, 8'd20}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_mem = 1'b0;
  logic        stream_en = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rd_data;
  logic        err;
  logic        bus_wr_n, bus_rd_n, bus_cs_n;
  logic        bus_rdy_n = 1'b1;
  logic [3:0]  bus_sub;
  logic [7:0]  bus_dout;
  logic        bus_doe;
  logic [7:0]  bus_din;

  always #5 clk = ~clk;

  hbus_master #(
    .PHASE_CYC(PHASE_CYC), .POLL_CYC(POLL_CYC),
    .POLL_MAX(POLL_MAX), .IDLE_WORDS(IDLE_WORDS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_mem(req_mem), .stream_en(stream_en),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rd_data(rd_data),
    .err(err), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_cs_n(bus_cs_n),
    .bus_rdy_n(bus_rdy_n), .bus_sub(bus_sub), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // slave model state
  logic [31:0] s_word = '0;
  logic [7:0]  s_dly = 8'd0;
  logic        s_armed = 1'b0;
  logic [7:0]  s_cd = 8'd0;

  // lane selected by the low two sub-address bits for both spaces
  always_comb bus_din = s_word >> {bus_sub[1:0], 3'b000};

  // bus log
  logic       log_rd  [16];
  logic [3:0] log_sub [16];
  logic [7:0] log_dat [16];
  int         log_n = 0;
  logic       exp_rd  [16];
  logic [3:0] exp_sub [16];
  logic [7:0] exp_dat [16];
  int         exp_n = 0;
  int gap_n = 0, viol2 = 0, viol7 = 0, viol11 = 0;
  logic p_wr_n = 1'b1, p_rd_n = 1'b1, p_cs_n = 1'b1, p_doe = 1'b0;
  logic [3:0] p_sub = 4'hF;
  logic [7:0] p_dout = 8'hFF;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_wr_n && !bus_cs_n && p_wr_n) begin
        if (!(p_cs_n && p_doe && bus_doe && p_sub == bus_sub && p_dout == bus_dout && bus_rd_n))
          viol2++;
        if (log_n < 16) begin
          log_rd[log_n] = 1'b0; log_sub[log_n] = bus_sub; log_dat[log_n] = bus_dout;
        end
        log_n++;
        if (bus_sub == 4'h7 || bus_sub == 4'hC) begin
          bus_rdy_n = 1'b1;
          s_armed   = (s_dly != 8'd255);
          s_cd      = s_dly;
        end
      end else if (s_armed) begin
        if (s_cd == 8'd0) bus_rdy_n = 1'b0;
        else s_cd = s_cd - 8'd1;
      end
      if (!bus_rd_n && p_rd_n) begin
        if (!(p_cs_n && !p_doe && p_sub == bus_sub && !bus_cs_n)) viol7++;
        if (log_n < 16) begin
          log_rd[log_n] = 1'b1; log_sub[log_n] = bus_sub; log_dat[log_n] = 8'h00;
        end
        log_n++;
      end
      if (bus_rd_n && !p_rd_n && !(bus_wr_n && bus_cs_n && !bus_doe)) viol7++;
      if (bus_doe && !bus_rd_n) viol11++;
      if (bus_doe && bus_sub == 4'hF && bus_dout == 8'hFF && bus_wr_n && bus_rd_n && bus_cs_n)
        gap_n++;
    end
    p_wr_n = bus_wr_n; p_rd_n = bus_rd_n; p_cs_n = bus_cs_n;
    p_doe = bus_doe; p_sub = bus_sub; p_dout = bus_dout;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input logic rd, input logic [3:0] sub, input logic [7:0] dat);
    exp_rd[exp_n] = rd; exp_sub[exp_n] = sub; exp_dat[exp_n] = dat;
    exp_n++;
  endtask

  task automatic build_exp(input vec_t v, input logic to);
    exp_n = 0;
    if (v.mem) begin
      if (v.wr) begin
        push(1'b0, 4'h8, v.wdata[7:0]);   push(1'b0, 4'h9, v.wdata[15:8]);
        push(1'b0, 4'hA, v.wdata[23:16]); push(1'b0, 4'hB, v.wdata[31:24]);
      end
      push(1'b0, 4'hE, {v.wr, 1'b0, v.addr[21:16]});
      push(1'b0, 4'hD, v.addr[15:8]);
      push(1'b0, 4'hC, v.addr[7:0]);
      if (!v.wr && !to) begin
        push(1'b1, 4'hB, 8'h00); push(1'b1, 4'hA, 8'h00);
        push(1'b1, 4'h9, 8'h00); push(1'b1, 4'h8, 8'h00);
      end
    end else begin
      if (v.wr) begin
        push(1'b0, 4'h0, v.wdata[7:0]);   push(1'b0, 4'h1, v.wdata[15:8]);
        push(1'b0, 4'h2, v.wdata[23:16]); push(1'b0, 4'h3, v.wdata[31:24]);
      end
      push(1'b0, 4'h4, v.addr[7:0]);
      push(1'b0, 4'h5, v.addr[15:8]);
      push(1'b0, 4'h7, v.wr ? 8'h01 : 8'h00);
      if (!v.wr && !to) begin
        push(1'b1, 4'h0, 8'h00); push(1'b1, 4'h1, 8'h00);
        push(1'b1, 4'h2, 8'h00); push(1'b1, 4'h3, 8'h00);
      end
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic        to;
    logic        seq_ok;
    logic [31:0] got_rd;
    logic        got_err;
    logic        seen;
    string       stag;
    to = (v.dly == 8'd255) && !(v.mem && v.wr && v.strm);
    build_exp(v, to);
    if (to && !v.wr)            stag = "R8";
    else if (v.strm && v.mem && v.wr) stag = "R9";
    else if (v.mem)             stag = v.wr ? "R5" : "R6";
    else                        stag = v.wr ? "R3" : "R4";
    @(negedge clk);
    log_n = 0; gap_n = 0; viol2 = 0; viol7 = 0; viol11 = 0;
    s_word = v.sword; s_dly = v.dly; s_armed = 1'b0; bus_rdy_n = 1'b1;
    req_valid = 1'b1; req_write = v.wr; req_mem = v.mem; stream_en = v.strm;
    req_addr = v.addr; req_wdata = v.wdata;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 req_ready low while busy", {31'd0, req_ready}, 32'd0);
    seen = 1'b0; got_rd = '0; got_err = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (done) begin
        seen = 1'b1; got_rd = rd_data; got_err = err;
      end else begin
        @(negedge clk);
      end
    end
    chk(seen, "R10 done arrives", {31'd0, seen}, 32'd1);
    @(negedge clk);
    chk(done == 1'b0, "R10 done single cycle", {31'd0, done}, 32'd0);
    seq_ok = (log_n == exp_n);
    for (int i = 0; i < 16; i++)
      if (seq_ok && i < exp_n)
        if (log_rd[i] != exp_rd[i] || log_sub[i] != exp_sub[i] || log_dat[i] != exp_dat[i])
          seq_ok = 1'b0;
    chk(seq_ok, {stag, " byte sequence"}, 32'(log_n), 32'(exp_n));
    chk(got_rd == ((!v.wr && !to) ? v.sword : 32'h0),
        v.wr ? "R10 write rd_data" : (to ? "R8 timeout rd_data" : (v.mem ? "R6 rd_data" : "R4 rd_data")),
        got_rd, (!v.wr && !to) ? v.sword : 32'h0);
    chk(got_err == to, to ? "R8 timeout err" : (v.strm ? "R9 stream err" : "R10 err"),
        {31'd0, got_err}, {31'd0, to});
    chk(gap_n == ((v.mem && v.wr && v.strm) ? IDLE_WORDS : 0), "R9 idle word count",
        32'(gap_n), (v.mem && v.wr && v.strm) ? 32'(IDLE_WORDS) : 32'd0);
    chk(viol2 == 0, "R2 write phases", 32'(viol2), 32'd0);
    chk(viol7 == 0, "R7 read phases", 32'(viol7), 32'd0);
    chk(viol11 == 0, "R11 no contention", 32'(viol11), 32'd0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected < 150000", cyc);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_wr_n && bus_rd_n && bus_cs_n, "R1 strobes high",
        {29'd0, bus_wr_n, bus_rd_n, bus_cs_n}, 32'd7);
    chk(bus_doe == 1'b0, "R1 output enable low", {31'd0, bus_doe}, 32'd0);
    chk(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
    chk(done == 1'b0 && err == 1'b0, "R1 done and err", {30'd0, done, err}, 32'd0);
    chk(rd_data == 32'd0, "R1 rd_data", rd_data, 32'd0);
    for (int k = 0; k < NV; k++) run_vec(VT[k]);
    // back-to-back repeat of a register read after a timeout
    run_vec(VT[6]);
    run_vec(VT[1]);
    chk(req_ready == 1'b1, "R10 idle after last request", {31'd0, req_ready}, 32'd1);
    finish_run();
  end

endmodule